// File: doc/BRIEF.md
# Router Output Channel Synchronizer

This block sits between the controller of a one-input, three-output packet router and the three output FIFOs. When the controller flags a header byte, the block stores the destination code carried in the two low bits of the input byte. From then on it routes the controller's single write request to the write enable of the selected FIFO. It also returns that FIFO's full flag to the controller, so the controller can stall the source.

The block also makes a valid-output flag for each channel from the FIFO's empty flag. These flags tell each receiver that data is waiting. Each channel has its own read watchdog. If the receiver leaves a non-empty channel unread for too long, the watchdog sends a one-cycle soft-reset pulse that flushes that FIFO. A stalled receiver therefore cannot hold its channel forever.

Top module: `rtr_chan_sync`

## Requirements
- R1: The destination code is taken from `hdr_addr` on each rising clock edge where `addr_capture` is high. It is held unchanged on edges where `addr_capture` is low.
- R2: `wr_en` is one-hot or zero and follows `wr_req` in the same cycle. Code 00 drives bit 0, code 01 drives bit 1 and code 10 drives bit 2. All bits are low while `wr_req` is low.
- R3: `sel_full` equals the `fifo_full` bit of the channel chosen by the stored code, in the same cycle.
- R4: While the stored code is 11, `sel_full` is 0 and every `wr_en` bit stays low, whatever `wr_req` and the full flags are.
- R5: `vld[i]` is the inverse of `fifo_empty[i]` in the same cycle.
- R6: A channel that sees `vld` high and `rd_en` low on 30 consecutive rising edges drives its `soft_rst` bit high for the cycle after the 30th of those edges.
- R7: The soft-reset pulse lasts exactly one cycle. Counting for that channel then starts again from zero, so a channel that is still stalled fires again 30 edges later.
- R8: A rising edge where that channel's `rd_en` is high, or where its `vld` is low, sets the count back to zero.
- R9: The three watchdogs are independent. A channel's pulse depends only on its own `vld` and `rd_en`.
- R10: While `rst_n` is low, the stored code becomes 11, all counts clear and `soft_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_capture | input | 1 | Controller flag marking a header byte |
| hdr_addr | input | 2 | Destination code, the low bits of the input byte |
| wr_req | input | 1 | Controller write request |
| rd_en | input | 3 | Read enable from each channel's receiver |
| fifo_full | input | 3 | Full flag of each FIFO |
| fifo_empty | input | 3 | Empty flag of each FIFO |
| sel_full | output | 1 | Full flag of the selected FIFO |
| wr_en | output | 3 | Write enable to each FIFO |
| vld | output | 3 | Data-waiting flag for each channel |
| soft_rst | output | 3 | One-cycle flush pulse for each FIFO |

## Verification
`wr_en`, `sel_full` and `vld` are combinational. The bench checks them 1 ns after it drives the inputs on a falling edge, within the same cycle. A new destination code takes effect only after the rising edge that captures it. The bench therefore checks routing one falling edge after it raises `addr_capture`. A watchdog pulse is due in the cycle after the 30th qualifying rising edge. The bench counts falling edges from the one where it set up the stall, and checks the pulse as absent after 29 edges, present after 30 and gone after 31.

// File: rtl/rtr_sync_pkg.sv
package rtr_sync_pkg;
  localparam int unsigned CH_NUM   = 3;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned RD_LIMIT = 30;
  localparam logic [CODE_W-1:0] CODE_NONE = '1;
endpackage

// File: rtl/rtr_code_latch.sv
module rtr_code_latch #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (cap) code_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '1;
    else        code_q <= code_d;
  end
endmodule

// File: rtl/rtr_wr_steer.sv
module rtr_wr_steer #(
  parameter int unsigned CH_NUM = 3,
  parameter int unsigned CODE_W = 2
) (
  input  logic [CODE_W-1:0] code,
  input  logic              wr_req,
  input  logic [CH_NUM-1:0] full_in,
  output logic              full_sel,
  output logic [CH_NUM-1:0] wr_en
);
  // one select line per channel; codes at or above CH_NUM select nothing
  logic [CH_NUM-1:0] hit;

  for (genvar g = 0; g < CH_NUM; g++) begin : g_dec
    assign hit[g]   = (code == CODE_W'(g));
    assign wr_en[g] = wr_req & hit[g];
  end

  assign full_sel = |(hit & full_in);
endmodule

// File: rtl/rtr_rd_watchdog.sv
module rtr_rd_watchdog #(
  parameter int unsigned LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic rd,
  output logic fire
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire_d;
  logic          stall;

  assign stall = vld & ~rd;

  always_comb begin
    cnt_d  = '0;
    fire_d = 1'b0;
    if (stall) begin
      if (cnt_q == LAST) fire_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fire  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fire  <= fire_d;
    end
  end
endmodule

// File: rtl/rtr_chan_sync.sv
module rtr_chan_sync
  import rtr_sync_pkg::*;
#(
  parameter int unsigned N_CH    = CH_NUM,
  parameter int unsigned A_W     = CODE_W,
  parameter int unsigned TIMEOUT = RD_LIMIT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_capture,
  input  logic [A_W-1:0]  hdr_addr,
  input  logic            wr_req,
  input  logic [N_CH-1:0] rd_en,
  input  logic [N_CH-1:0] fifo_full,
  input  logic [N_CH-1:0] fifo_empty,
  output logic            sel_full,
  output logic [N_CH-1:0] wr_en,
  output logic [N_CH-1:0] vld,
  output logic [N_CH-1:0] soft_rst
);
  logic [A_W-1:0] code_q;

  rtr_code_latch #(.CODE_W(A_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (addr_capture),
    .code_in (hdr_addr),
    .code_q  (code_q)
  );

  rtr_wr_steer #(.CH_NUM(N_CH), .CODE_W(A_W)) u_steer (
    .code     (code_q),
    .wr_req   (wr_req),
    .full_in  (fifo_full),
    .full_sel (sel_full),
    .wr_en    (wr_en)
  );

  assign vld = ~fifo_empty;

  for (genvar g = 0; g < N_CH; g++) begin : g_wd
    rtr_rd_watchdog #(.LIMIT(TIMEOUT)) u_wd (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (vld[g]),
      .rd    (rd_en[g]),
      .fire  (soft_rst[g])
    );
  end
endmodule

// File: rtl/rtr_chan_sync_chk.sv
module rtr_chan_sync_chk #(
  parameter int unsigned N_CH = 3,
  parameter int unsigned A_W  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            addr_capture,
  input logic [A_W-1:0]  hdr_addr,
  input logic            wr_req,
  input logic [N_CH-1:0] rd_en,
  input logic [N_CH-1:0] fifo_full,
  input logic [N_CH-1:0] fifo_empty,
  input logic            sel_full,
  input logic [N_CH-1:0] wr_en,
  input logic [N_CH-1:0] vld,
  input logic [N_CH-1:0] soft_rst
);
  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_en));

  // R2
  wr_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_en != '0) |-> wr_req);

  // R4
  none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_capture && hdr_addr == '1) |=> (!sel_full && wr_en == '0));

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    // R7
    pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n) soft_rst[g] |=> !soft_rst[g]);

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst[g]) |-> $past(vld[g] && !rd_en[g]));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en[g] |=> !soft_rst[g]);
  end
endmodule

bind rtr_chan_sync rtr_chan_sync_chk #(.N_CH(N_CH), .A_W(A_W)) u_chk (.*);

// File: tb/rtr_chan_sync_tb.sv
module rtr_chan_sync_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_capture;
  logic [1:0] hdr_addr;
  logic       wr_req;
  logic [2:0] rd_en, fifo_full, fifo_empty;
  logic       sel_full;
  logic [2:0] wr_en, vld, soft_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rtr_chan_sync u_dut (
    .clk(clk), .rst_n(rst_n), .addr_capture(addr_capture), .hdr_addr(hdr_addr),
    .wr_req(wr_req), .rd_en(rd_en), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .sel_full(sel_full), .wr_en(wr_en), .vld(vld), .soft_rst(soft_rst)
  );

  // {code, wr_req, full[2:0], exp_wr_en[2:0], exp_sel_full}
  localparam logic [9:0] VEC [8] = '{
    {2'b00, 1'b1, 3'b001, 3'b001, 1'b1},
    {2'b00, 1'b1, 3'b110, 3'b001, 1'b0},
    {2'b01, 1'b1, 3'b010, 3'b010, 1'b1},
    {2'b01, 1'b0, 3'b101, 3'b000, 1'b0},
    {2'b10, 1'b1, 3'b100, 3'b100, 1'b1},
    {2'b10, 1'b1, 3'b011, 3'b100, 1'b0},
    {2'b11, 1'b1, 3'b111, 3'b000, 1'b0},
    {2'b01, 1'b1, 3'b000, 3'b010, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capture(input logic [1:0] c);
    addr_capture = 1'b1; hdr_addr = c;
    step(1);
    addr_capture = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_capture = 1'b0; hdr_addr = 2'b00; wr_req = 1'b1;
    rd_en = 3'b000; fifo_full = 3'b111; fifo_empty = 3'b101;
    step(3);
    #1;
    // R10: stored code 11 after reset, so no write routing
    chk("R10 wr_en", 8'(wr_en), 8'h0);
    chk("R10 sel_full", 8'(sel_full), 8'h0);
    chk("R10 soft_rst", 8'(soft_rst), 8'h0);
    // R5
    chk("R5 vld", 8'(vld), 8'h2);
    rst_n = 1'b1; fifo_empty = 3'b111;
    step(1);

    // R1 R2 R3 R4 table walk
    for (int i = 0; i < 8; i++) begin
      wr_req = 1'b0;
      capture(VEC[i][9:8]);
      wr_req = VEC[i][7]; fifo_full = VEC[i][6:4];
      #1;
      chk("R2 wr_en", 8'(wr_en), 8'(VEC[i][3:1]));
      chk("R3 sel_full", 8'(sel_full), 8'(VEC[i][0]));
      step(1);
    end

    // R1: hold while capture is low
    capture(2'b10);
    hdr_addr = 2'b00; wr_req = 1'b1; fifo_full = 3'b001;
    step(2); #1;
    chk("R1 hold wr_en", 8'(wr_en), 8'h4);
    chk("R1 hold sel_full", 8'(sel_full), 8'h0);
    // R4
    capture(2'b11);
    fifo_full = 3'b111; #1;
    chk("R4 wr_en", 8'(wr_en), 8'h0);
    chk("R4 sel_full", 8'(sel_full), 8'h0);
    wr_req = 1'b0;
    // R5
    fifo_empty = 3'b010; #1;
    chk("R5 vld", 8'(vld), 8'h5);
    fifo_empty = 3'b111;
    step(2);

    // R6 R7: channel 0 stalls
    fifo_empty = 3'b110;
    step(29); chk("R6 before", 8'(soft_rst), 8'h0);
    step(1);  chk("R6 fire", 8'(soft_rst), 8'h1);
    step(1);  chk("R7 one cycle", 8'(soft_rst), 8'h0);
    step(28); chk("R7 before refire", 8'(soft_rst), 8'h0);
    step(1);  chk("R7 refire", 8'(soft_rst), 8'h1);
    fifo_empty = 3'b111;
    step(2);

    // R8: read clears
    fifo_empty = 3'b110;
    step(20); rd_en = 3'b001;
    step(1);  rd_en = 3'b000;
    step(29); chk("R8 read cleared", 8'(soft_rst), 8'h0);
    step(1);  chk("R8 fire after read", 8'(soft_rst), 8'h1);
    fifo_empty = 3'b111;
    step(2);
    // R8: valid low clears
    fifo_empty = 3'b110;
    step(15); fifo_empty = 3'b111;
    step(1);  fifo_empty = 3'b110;
    step(29); chk("R8 vld cleared", 8'(soft_rst), 8'h0);
    step(1);  chk("R8 fire after gap", 8'(soft_rst), 8'h1);
    fifo_empty = 3'b111;
    step(2);

    // R9: channels independent
    fifo_empty = 3'b110;
    step(5);  fifo_empty = 3'b100;
    step(25); chk("R9 ch0 only", 8'(soft_rst), 8'h1);
    step(5);  chk("R9 ch1 only", 8'(soft_rst), 8'h2);
    fifo_empty = 3'b111;
    step(2);

    // R10: reset mid-count clears
    fifo_empty = 3'b011;
    step(20); rst_n = 1'b0;
    step(1);  rst_n = 1'b1;
    step(29); chk("R10 count cleared", 8'(soft_rst), 8'h0);
    step(1);  chk("R10 fire after reset", 8'(soft_rst), 8'h4);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule